// File: doc/BRIEF.md
# Interrupt Cause Register with Count/Compare Timer

This block keeps a processor's interrupt-cause word together with a free-running count/compare timer. Eight level-sensitive request lines each own one pending bit. When a line changes level, its pending bit takes the new level. Software can also write a small set of cause bits. An exception entry unit feeds in the exception code, the coprocessor number and the branch-delay information. The timer drives pending bit 15 and, in the second architecture revision, a separate timer flag.

A 3-bit static revision input selects the feature set. The revision-2 features (the timer flag and a writable count-disable bit that freezes the timer) apply only when this input equals 1. The block also gives a single registered interrupt-pending output, which is the OR of all eight pending bits. Masking and priority are left to the logic that consumes the cause word.

Top module: `irq_cause_unit`

## Requirements
- R1: When request line i (0..7) changes level, cause bit 8+i takes the new level on the next clock edge. A line that does not change leaves its bit alone.
- R2: While cause bit 27 (count disable) is 1, the count does not advance on a tick and no compare match is taken.
- R3: A tick with the count equal to compare sets cause bit 15. When revision is 1 it also sets cause bit 30. When revision is not 1, bit 30 stays 0.
- R4: A compare write loads compare and clears cause bit 15. When revision is 1 it also clears bit 30. A compare write in the same cycle as a match wins, so bit 15 stays 0.
- R5: A software cause write replaces only bits 8, 9, 22 and 23 (mask 0x00C00300), plus bit 27 when revision is 1. All other bits keep their value.
- R6: Bits 8 and 9 set by software raise the pending output like hardware lines. A line change in the same cycle as a software write to the same bit wins.
- R7: irqPending equals the OR of cause bits 15:8 as they were one cycle earlier.
- R8: An exception entry writes the exception code to bits 6:2 and the coprocessor number to bits 29:28. Bit 31 is set when the exception is in a delay slot and EXL was clear. It is held when the exception is in a delay slot and EXL was set. It is cleared when the exception is not in a delay slot.
- R9: After reset the cause word is 0, irqPending is 0, the count is 0 and compare is all ones. Each enabled tick adds one to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| irqLines | input | 8 | Level-sensitive interrupt request lines |
| tickEn | input | 1 | Timer tick enable |
| swWe | input | 1 | Software cause write strobe |
| swData | input | 32 | Software cause write data |
| cmpWe | input | 1 | Compare write strobe |
| cmpData | input | 32 | Compare write data |
| rev | input | 3 | Architecture revision; revision-2 features when 1 |
| excValid | input | 1 | Exception entry strobe |
| excCode | input | 5 | Exception code |
| excCe | input | 2 | Coprocessor number for unusable-coprocessor exceptions |
| excInDelay | input | 1 | Exception raised in a branch delay slot |
| excExl | input | 1 | Exception level was already set |
| causeWord | output | 32 | Cause register |
| irqPending | output | 1 | Registered OR of pending bits |
| countValue | output | 32 | Current count |

## Verification
The pending bits are driven with a single line, then a mixed pattern (0x5A), then a release. This separates per-bit routing from a shared update and shows the one-cycle lag of the pending output. Software writes of all ones and all zeros under both revisions expose the write mask, including whether bit 27 is writable. Compare matches are tried in both revisions, with the count-disable bit set and cleared, and with a compare write in the same cycle as a match, which separates the timer flag, freeze and precedence rules. Exception entries cycle through the delay-slot and EXL combinations to pin down the set, hold and clear behaviour of bit 31.

// File: rtl/cause_pkg.sv
package cause_pkg;
  localparam int NUM_LINES = 8;
  localparam int IP_LSB    = 8;
  localparam int BIT_TIMER = 15;
  localparam int BIT_DC    = 27;
  localparam int BIT_TI    = 30;
  localparam int BIT_BD    = 31;
  localparam int CE_LSB    = 28;
  localparam int EXC_LSB   = 2;
  localparam logic [31:0] SW_MASK_BASE = 32'h00C0_0300;
  localparam logic [2:0]  REV_R2       = 3'd1;

  typedef struct packed {
    logic                 countStep;
    logic                 timerSet;
    logic                 timerClr;
    logic                 tiSet;
    logic                 tiClr;
    logic [NUM_LINES-1:0] lineChg;
    logic [NUM_LINES-1:0] lineLvl;
    logic                 swWr;
    logic [31:0]          swMask;
  } causeStrobe_t;
endpackage

// File: rtl/cause_ctrl.sv
module cause_ctrl
  import cause_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic                 tickEn,
  input  logic                 cmpWe,
  input  logic                 swWe,
  input  logic [2:0]           rev,
  input  logic                 dcBit,
  input  logic                 cntEqCmp,
  output causeStrobe_t         stb
);
  logic [NUM_LINES-1:0] linePrev;
  logic                 isR2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linePrev <= '0;
    else       linePrev <= irqLines;
  end

  assign isR2 = (rev == REV_R2);

  always_comb begin
    stb           = '0;
    stb.countStep = tickEn & ~dcBit;
    // a compare write takes precedence over a match in the same cycle
    stb.timerSet  = tickEn & ~dcBit & cntEqCmp & ~cmpWe;
    stb.timerClr  = cmpWe;
    stb.tiSet     = tickEn & ~dcBit & cntEqCmp & ~cmpWe & isR2;
    stb.tiClr     = cmpWe & isR2;
    stb.lineChg   = irqLines ^ linePrev;
    stb.lineLvl   = irqLines;
    stb.swWr      = swWe;
    stb.swMask    = SW_MASK_BASE;
    stb.swMask[BIT_DC] = isR2;
  end

  // R2: a frozen count never produces a step or a match strobe
  a_r2_no_step_frozen: assert property (@(posedge clk) disable iff (!rstN)
    dcBit |-> !(stb.countStep || stb.timerSet));
endmodule

// File: rtl/cause_dp.sv
module cause_dp
  import cause_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  causeStrobe_t     stb,
  input  logic [31:0]      swData,
  input  logic [CNT_W-1:0] cmpData,
  input  logic             excValid,
  input  logic [4:0]       excCode,
  input  logic [1:0]       excCe,
  input  logic             excInDelay,
  input  logic             excExl,
  output logic [31:0]      causeQ,
  output logic [CNT_W-1:0] countQ,
  output logic             cntEqCmp,
  output logic             dcBit
);
  logic [CNT_W-1:0] compareQ;
  logic [31:0]      causeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ   <= '0;
      compareQ <= '1;
    end else begin
      if (stb.countStep) countQ   <= countQ + 1'b1;
      if (stb.timerClr)  compareQ <= cmpData;
    end
  end

  assign cntEqCmp = (countQ == compareQ);
  assign dcBit    = causeQ[BIT_DC];

  always_comb begin
    causeN = causeQ;
    if (stb.swWr) causeN = (causeQ & ~stb.swMask) | (swData & stb.swMask);
    if (excValid) begin
      causeN[EXC_LSB +: 5] = excCode;
      causeN[CE_LSB +: 2]  = excCe;
      if (!excInDelay)  causeN[BIT_BD] = 1'b0;
      else if (!excExl) causeN[BIT_BD] = 1'b1;
    end
    for (int i = 0; i < NUM_LINES; i++)
      if (stb.lineChg[i]) causeN[IP_LSB + i] = stb.lineLvl[i];
    if (stb.timerSet) causeN[BIT_TIMER] = 1'b1;
    if (stb.timerClr) causeN[BIT_TIMER] = 1'b0;
    if (stb.tiSet)    causeN[BIT_TI]    = 1'b1;
    if (stb.tiClr)    causeN[BIT_TI]    = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) causeQ <= '0;
    else       causeQ <= causeN;
  end

  a_r2_count_frozen: assert property (@(posedge clk) disable iff (!rstN)
    causeQ[BIT_DC] |=> countQ == $past(countQ));
  a_r3_match_sets: assert property (@(posedge clk) disable iff (!rstN)
    stb.timerSet |=> causeQ[BIT_TIMER]);
  a_r4_cmp_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.timerClr |=> !causeQ[BIT_TIMER]);
  a_r5_sw_keeps_dc: assert property (@(posedge clk) disable iff (!rstN)
    (stb.swWr && !stb.swMask[BIT_DC]) |=> causeQ[BIT_DC] == $past(causeQ[BIT_DC]));
  a_r8_bd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excInDelay && excExl) |=> causeQ[BIT_BD] == $past(causeQ[BIT_BD]));

  for (genvar g = 0; g < NUM_LINES - 1; g++) begin : g_lineChk
    a_r1_line_follow: assert property (@(posedge clk) disable iff (!rstN)
      stb.lineChg[g] |=> causeQ[IP_LSB + g] == $past(stb.lineLvl[g]));
  end
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import cause_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       irqLines,
  input  logic             tickEn,
  input  logic             swWe,
  input  logic [31:0]      swData,
  input  logic             cmpWe,
  input  logic [CNT_W-1:0] cmpData,
  input  logic [2:0]       rev,
  input  logic             excValid,
  input  logic [4:0]       excCode,
  input  logic [1:0]       excCe,
  input  logic             excInDelay,
  input  logic             excExl,
  output logic [31:0]      causeWord,
  output logic             irqPending,
  output logic [CNT_W-1:0] countValue
);
  causeStrobe_t stb;
  logic         dcBit;
  logic         cntEqCmp;

  cause_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .tickEn(tickEn),
    .cmpWe(cmpWe), .swWe(swWe), .rev(rev), .dcBit(dcBit),
    .cntEqCmp(cntEqCmp), .stb(stb)
  );

  cause_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .swData(swData), .cmpData(cmpData),
    .excValid(excValid), .excCode(excCode), .excCe(excCe),
    .excInDelay(excInDelay), .excExl(excExl), .causeQ(causeWord),
    .countQ(countValue), .cntEqCmp(cntEqCmp), .dcBit(dcBit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqPending <= 1'b0;
    else       irqPending <= |causeWord[IP_LSB +: NUM_LINES];
  end

  a_r7_pending_lag: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqPending == $past(|causeWord[IP_LSB +: NUM_LINES]));
endmodule

// File: tb/irq_cause_unit_bench.sv
`timescale 1ns/1ps
module irq_cause_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  irqLines = '0;
  logic        tickEn = 1'b0, swWe = 1'b0, cmpWe = 1'b0;
  logic [31:0] swData = '0, cmpData = '0;
  logic [2:0]  rev = '0;
  logic        excValid = 1'b0, excInDelay = 1'b0, excExl = 1'b0;
  logic [4:0]  excCode = '0;
  logic [1:0]  excCe = '0;
  logic [31:0] causeWord, countValue;
  logic        irqPending;
  int          errors = 0, checks = 0;

  always #4 clk = ~clk;

  irq_cause_unit u_irq_cause_unit (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .tickEn(tickEn), .swWe(swWe),
    .swData(swData), .cmpWe(cmpWe), .cmpData(cmpData), .rev(rev),
    .excValid(excValid), .excCode(excCode), .excCe(excCe),
    .excInDelay(excInDelay), .excExl(excExl), .causeWord(causeWord),
    .irqPending(irqPending), .countValue(countValue)
  );

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R9 reset cause", causeWord, 32'h0);
    chk("R9 reset pending", {31'b0, irqPending}, 32'h0);
    chk("R9 reset count", countValue, 32'h0);
  endtask

  task automatic t_lines();
    irqLines = 8'h08; step();
    chk("R1 line3 sets bit11", causeWord, 32'h0000_0800);
    chk("R7 pending lags", {31'b0, irqPending}, 32'h0);
    step();
    chk("R7 pending up", {31'b0, irqPending}, 32'h1);
    irqLines = 8'h5A; step();
    chk("R1 pattern 5A", causeWord, 32'h0000_5A00);
    irqLines = 8'h00; step();
    chk("R1 release", causeWord, 32'h0);
    step();
    chk("R7 pending down", {31'b0, irqPending}, 32'h0);
  endtask

  task automatic t_sw();
    rev = 3'd0; swWe = 1'b1; swData = 32'hFFFF_FFFF; step();
    chk("R5 rev0 mask", causeWord, 32'h00C0_0300);
    swWe = 1'b0; step();
    chk("R6 sw bits pend", {31'b0, irqPending}, 32'h1);
    swWe = 1'b1; swData = 32'h0; step();
    chk("R5 sw clear", causeWord, 32'h0);
    irqLines = 8'h01; step();
    chk("R6 line beats sw", causeWord, 32'h0000_0100);
    swWe = 1'b0; irqLines = 8'h00; step();
    chk("R1 line0 clear", causeWord, 32'h0);
  endtask

  task automatic t_exc();
    excValid = 1'b1; excCode = 5'd12; excCe = 2'd2; excInDelay = 1'b1; excExl = 1'b0; step();
    chk("R8 bd set", causeWord, 32'hA000_0030);
    excCode = 5'd5; excCe = 2'd1; excExl = 1'b1; step();
    chk("R8 bd held set", causeWord, 32'h9000_0014);
    excCode = 5'd0; excCe = 2'd0; excInDelay = 1'b0; excExl = 1'b0; step();
    chk("R8 bd cleared", causeWord, 32'h0);
    excInDelay = 1'b1; excExl = 1'b1; step();
    chk("R8 bd held clear", causeWord, 32'h0);
    excValid = 1'b0; excInDelay = 1'b0; excExl = 1'b0; step();
  endtask

  task automatic t_timer_rev0();
    logic [31:0] c;
    rev = 3'd0; c = countValue;
    cmpWe = 1'b1; cmpData = c + 32'd4; step(); cmpWe = 1'b0;
    tickEn = 1'b1;
    for (int i = 0; i < 4; i++) step();
    chk("R9 count steps", countValue, c + 32'd4);
    chk("R3 no early match", causeWord, 32'h0);
    step(); tickEn = 1'b0;
    chk("R3 rev0 match", causeWord, 32'h0000_8000);
    chk("R9 count after match", countValue, c + 32'd5);
    cmpWe = 1'b1; cmpData = c + 32'd100; step(); cmpWe = 1'b0;
    chk("R4 cmp clears", causeWord, 32'h0);
  endtask

  task automatic t_timer_rev1();
    logic [31:0] c;
    rev = 3'd1; c = countValue;
    cmpWe = 1'b1; cmpData = c + 32'd2; step(); cmpWe = 1'b0;
    tickEn = 1'b1;
    for (int i = 0; i < 3; i++) step();
    tickEn = 1'b0;
    chk("R3 rev1 match sets ti", causeWord, 32'h4000_8000);
    cmpWe = 1'b1; cmpData = countValue; step(); cmpWe = 1'b0;
    chk("R4 rev1 cmp clears ti", causeWord, 32'h0);
    c = countValue;
    tickEn = 1'b1; cmpWe = 1'b1; cmpData = c + 32'd50; step();
    tickEn = 1'b0; cmpWe = 1'b0;
    chk("R4 cmp beats match", causeWord, 32'h0);
    chk("R9 count stepped", countValue, c + 32'd1);
  endtask

  task automatic t_freeze();
    logic [31:0] c;
    rev = 3'd1; swWe = 1'b1; swData = 32'h0800_0000; step(); swWe = 1'b0;
    chk("R5 rev1 dc writable", causeWord, 32'h0800_0000);
    c = countValue;
    cmpWe = 1'b1; cmpData = c; step(); cmpWe = 1'b0;
    tickEn = 1'b1;
    for (int i = 0; i < 5; i++) step();
    chk("R2 count frozen", countValue, c);
    chk("R2 no match frozen", causeWord, 32'h0800_0000);
    swWe = 1'b1; swData = 32'h0; step(); swWe = 1'b0;
    chk("R2 dc clear cycle frozen", countValue, c);
    chk("R5 dc cleared", causeWord, 32'h0);
    step(); tickEn = 1'b0;
    chk("R2 match after thaw", causeWord, 32'h4000_8000);
    cmpWe = 1'b1; cmpData = 32'hFFFF_FFFF; step(); cmpWe = 1'b0;
    rev = 3'd0; swWe = 1'b1; swData = 32'h0800_0000; step(); swWe = 1'b0;
    chk("R5 rev0 dc not writable", causeWord, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_lines();
    t_sw();
    t_exc();
    t_timer_rev0();
    t_timer_rev1();
    t_freeze();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule